// File: doc/BRIEF.md
# Block-Transfer Address Sequencer

This block turns a single multi-register memory transfer request into a stream of single-word accesses. A request carries a base address, a 16-bit register selection mask, a direction-of-data flag (load or store), two stack-shape flags (full or empty, ascending or descending) and a writeback flag. The block picks the selected registers one at a time, lowest index first, and pairs each with a word address. It presents them on a valid/ready access port, one per cycle while the consumer accepts.

After the last access the block pulses a completion strobe. It also reports the updated base value and whether the caller should write it back. A restricted mode for compact-encoding push/pop operations can be selected per request. In that mode the stack shape is fixed to full-descending, writeback is forced on, and the register mask is limited to the low eight registers plus one extra slot. The extra slot is the link register on a store and the program counter on a load.

An empty mask, or a mask that breaks the restricted-mode rules, finishes with no accesses and sets an error flag. The register file, the memory and instruction decode sit outside this block.

Top module: `lsm_addr_seq`

## Requirements
- R1: Every set bit of `req_list_i` (bit i selects register i) produces exactly one accepted access whose `acc_reg_o` is i. The accesses come out in strictly increasing register order.
- R2: Consecutive accesses of one request have addresses that rise by 4. The lowest selected register therefore sits at the lowest address, whatever the stack shape.
- R3: With N selected registers and the aligned base B, the first address is as follows. For a store: full-descending B-4N, empty-descending B-4N+4, full-ascending B+4, empty-ascending B. For a load: full-descending B, empty-descending B+4, full-ascending B-4N+4, empty-ascending B-4N. `req_full_i`=1 means full, `req_asc_i`=1 means ascending and `req_load_i`=1 means load.
- R4: The reported final base is B-4N for a descending store or an ascending load, and B+4N otherwise. `wb_en_o` equals `req_wb_i` for a legal request.
- R5: Every access address has its two low bits at zero. The low two bits of `req_base_i` are ignored.
- R6: An all-zero mask issues no access, raises `illegal_o`, clears `wb_en_o` and pulses `done_o` in the cycle after the request is accepted.
- R7: When `req_restrict_i` is 1, the request behaves as full-descending with writeback on, regardless of `req_full_i`, `req_asc_i` and `req_wb_i`. Registers 0..7 are allowed, plus register 14 on a store or register 15 on a load.
- R8: A restricted-mode mask that names any other register issues no access, raises `err_o`, clears `wb_en_o` and pulses `done_o` in the cycle after acceptance.
- R9: While `acc_valid_o` is high and `acc_ready_i` is low, the access register and address hold. One access is accepted per cycle in which both are high.
- R10: `done_o` is a one-cycle pulse in the cycle after the last access is accepted. `req_ready_o` is high only when the block is idle, and never together with `acc_valid_o`.
- R11: After reset `req_ready_o` is 1, and `acc_valid_o`, `done_o`, `wb_en_o`, `illegal_o` and `err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Block idle and able to take a request |
| req_base_i | input | ADDR_W | Base address (low two bits ignored) |
| req_list_i | input | NUM_REGS | Register selection mask, bit i = register i |
| req_load_i | input | 1 | 1 = load (pop), 0 = store (push) |
| req_full_i | input | 1 | 1 = full stack, 0 = empty stack |
| req_asc_i | input | 1 | 1 = ascending stack, 0 = descending |
| req_wb_i | input | 1 | Request writeback of the final base |
| req_restrict_i | input | 1 | Restricted push/pop mode |
| acc_valid_o | output | 1 | Access offered |
| acc_ready_i | input | 1 | Access accepted by memory side |
| acc_reg_o | output | REG_W | Register index of the access |
| acc_addr_o | output | ADDR_W | Word address of the access |
| acc_load_o | output | 1 | Access direction, 1 = load |
| done_o | output | 1 | One-cycle completion pulse |
| wb_en_o | output | 1 | Caller should write back `wb_value_o` |
| wb_value_o | output | ADDR_W | Final base value |
| illegal_o | output | 1 | Last request had an empty mask |
| err_o | output | 1 | Last request broke restricted-mode rules |

## Verification
The assertions assume that every input is a known value from reset onward, and that `acc_ready_i` may change freely between cycles. The hold and step checks rest only on the block's own state. The request fields are sampled only at the accepting edge, so the assertions do not depend on them staying stable. The bench drives every input at the falling edge. It raises `req_valid_i` only while `req_ready_o` is high and drops it after one accepting cycle. It stalls `acc_ready_i` in a fixed alternating pattern in some cases, so the hold property is exercised as well as the back-to-back path.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned WORD_SHIFT = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/lsm_list_check.sv
module lsm_list_check #(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned LOW_REGS = 8,
  parameter int unsigned LINK_IDX = 14,
  parameter int unsigned PC_IDX   = 15,
  parameter int unsigned CNT_W    = $clog2(NUM_REGS + 1)
) (
  input  logic [NUM_REGS-1:0] list_i,
  input  logic                restrict_i,
  input  logic                load_i,
  output logic [CNT_W-1:0]    cnt_o,
  output logic                empty_o,
  output logic                bad_o
);
  logic [NUM_REGS-1:0] allow;

  // restricted mode: low registers plus one direction-dependent slot
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_allow
    if (g < LOW_REGS) begin : g_low
      assign allow[g] = 1'b1;
    end else if (g == LINK_IDX) begin : g_link
      assign allow[g] = ~load_i;
    end else if (g == PC_IDX) begin : g_pc
      assign allow[g] = load_i;
    end else begin : g_high
      assign allow[g] = 1'b0;
    end
  end

  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      cnt_o = cnt_o + CNT_W'(list_i[i]);
    end
  end

  assign empty_o = ~|list_i;
  assign bad_o   = restrict_i & |(list_i & ~allow);
endmodule

// File: rtl/lsm_addr_plan.sv
module lsm_addr_plan
  import lsm_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 5
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              full_i,
  input  logic              asc_i,
  input  logic              load_i,
  input  logic              restrict_i,
  output logic [ADDR_W-1:0] start_o,
  output logic [ADDR_W-1:0] final_o
);
  logic [ADDR_W-1:0] aligned, span, word;
  logic              eff_full, eff_asc, grow_up, step_first;

  assign aligned    = {base_i[ADDR_W-1:WORD_SHIFT], WORD_SHIFT'(0)};
  assign span       = ADDR_W'(cnt_i) << WORD_SHIFT;
  assign word       = ADDR_W'(WORD_BYTES);
  assign eff_full   = restrict_i | full_i;
  assign eff_asc    = ~restrict_i & asc_i;
  // a load walks the stack opposite to a store of the same shape
  assign grow_up    = eff_asc ^ load_i;
  assign step_first = eff_full ^ load_i;

  always_comb begin
    if (grow_up) begin
      start_o = step_first ? aligned + word : aligned;
      final_o = aligned + span;
    end else begin
      start_o = step_first ? aligned - span : aligned - span + word;
      final_o = aligned - span;
    end
  end
endmodule

// File: rtl/lsm_pick.sv
module lsm_pick #(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned REG_W    = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0] mask_i,
  output logic [REG_W-1:0]    idx_o,
  output logic [NUM_REGS-1:0] onehot_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NUM_REGS - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = REG_W'(i);
    end
  end

  assign onehot_o = mask_i & ~(mask_i - NUM_REGS'(1));
endmodule

// File: rtl/lsm_addr_seq.sv
module lsm_addr_seq
  import lsm_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned LOW_REGS = 8,
  parameter int unsigned LINK_IDX = 14,
  parameter int unsigned PC_IDX   = 15,
  parameter int unsigned REG_W    = $clog2(NUM_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [ADDR_W-1:0]   req_base_i,
  input  logic [NUM_REGS-1:0] req_list_i,
  input  logic                req_load_i,
  input  logic                req_full_i,
  input  logic                req_asc_i,
  input  logic                req_wb_i,
  input  logic                req_restrict_i,
  output logic                acc_valid_o,
  input  logic                acc_ready_i,
  output logic [REG_W-1:0]    acc_reg_o,
  output logic [ADDR_W-1:0]   acc_addr_o,
  output logic                acc_load_o,
  output logic                done_o,
  output logic                wb_en_o,
  output logic [ADDR_W-1:0]   wb_value_o,
  output logic                illegal_o,
  output logic                err_o
);
  localparam int unsigned CNT_W = $clog2(NUM_REGS + 1);

  seq_state_e          state_q;
  logic [NUM_REGS-1:0] mask_q, pick_hot, mask_left;
  logic [ADDR_W-1:0]   addr_q, start_addr, final_addr, wb_val_q;
  logic [CNT_W-1:0]    sel_cnt;
  logic                load_q, wb_en_q, illegal_q, err_q;
  logic                list_empty, list_bad, take_req, take_acc;

  lsm_list_check #(
    .NUM_REGS(NUM_REGS), .LOW_REGS(LOW_REGS), .LINK_IDX(LINK_IDX),
    .PC_IDX(PC_IDX), .CNT_W(CNT_W)
  ) u_check (
    .list_i(req_list_i), .restrict_i(req_restrict_i), .load_i(req_load_i),
    .cnt_o(sel_cnt), .empty_o(list_empty), .bad_o(list_bad)
  );

  lsm_addr_plan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_plan (
    .base_i(req_base_i), .cnt_i(sel_cnt), .full_i(req_full_i),
    .asc_i(req_asc_i), .load_i(req_load_i), .restrict_i(req_restrict_i),
    .start_o(start_addr), .final_o(final_addr)
  );

  lsm_pick #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_pick (
    .mask_i(mask_q), .idx_o(acc_reg_o), .onehot_o(pick_hot)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign acc_valid_o = (state_q == ST_BUSY);
  assign done_o      = (state_q == ST_DONE);
  assign acc_addr_o  = addr_q;
  assign acc_load_o  = load_q;
  assign wb_en_o     = wb_en_q;
  assign wb_value_o  = wb_val_q;
  assign illegal_o   = illegal_q;
  assign err_o       = err_q;

  assign take_req  = req_valid_i & req_ready_o;
  assign take_acc  = acc_valid_o & acc_ready_i;
  assign mask_left = mask_q & ~pick_hot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      mask_q    <= '0;
      addr_q    <= '0;
      load_q    <= 1'b0;
      wb_en_q   <= 1'b0;
      wb_val_q  <= '0;
      illegal_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (take_req) begin
          mask_q    <= req_list_i;
          addr_q    <= start_addr;
          load_q    <= req_load_i;
          wb_val_q  <= final_addr;
          illegal_q <= list_empty;
          err_q     <= list_bad;
          wb_en_q   <= ~list_empty & ~list_bad & (req_wb_i | req_restrict_i);
          state_q   <= (list_empty | list_bad) ? ST_DONE : ST_BUSY;
        end
        ST_BUSY: if (take_acc) begin
          mask_q <= mask_left;
          addr_q <= addr_q + ADDR_W'(WORD_BYTES);
          if (mask_left == '0) state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // access port holds while stalled
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_o && !acc_ready_i) |=> (acc_valid_o && $stable(acc_addr_o) && $stable(acc_reg_o)));

  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_o && acc_ready_i) |=> (!acc_valid_o || acc_addr_o == $past(acc_addr_o) + ADDR_W'(4)));

  assert_order_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_o && acc_ready_i) |=> (!acc_valid_o || acc_reg_o > $past(acc_reg_o)));

  assert_align_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_o |-> (acc_addr_o[1:0] == 2'b00));

  assert_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && req_ready_o));

  assert_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_ready_o && acc_valid_o));

  assert_empty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && illegal_o) |-> !wb_en_o);

  assert_bad_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (!wb_en_o && !illegal_o));

  assert_noacc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && req_valid_i && req_list_i == '0) |=> (!acc_valid_o && done_o));
endmodule

// File: tb/lsm_addr_seq_tb.sv
`timescale 1ns/1ps
module lsm_addr_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_base = '0;
  logic [15:0] req_list = '0;
  logic        req_load = 1'b0, req_full = 1'b0, req_asc = 1'b0, req_wb = 1'b0, req_rstr = 1'b0;
  logic        acc_valid, acc_ready = 1'b1, acc_load;
  logic [3:0]  acc_reg;
  logic [31:0] acc_addr, wb_value;
  logic        done, wb_en, illegal, err;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  lsm_addr_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_base_i(req_base), .req_list_i(req_list), .req_load_i(req_load),
    .req_full_i(req_full), .req_asc_i(req_asc), .req_wb_i(req_wb),
    .req_restrict_i(req_rstr),
    .acc_valid_o(acc_valid), .acc_ready_i(acc_ready), .acc_reg_o(acc_reg),
    .acc_addr_o(acc_addr), .acc_load_o(acc_load),
    .done_o(done), .wb_en_o(wb_en), .wb_value_o(wb_value),
    .illegal_o(illegal), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected start/final from the requirement table
  task automatic plan(input logic [31:0] base, input int n, input bit ld, input bit full,
                      input bit asc, output logic [31:0] st, output logic [31:0] fin);
    logic [31:0] b, s;
    b = {base[31:2], 2'b00};
    s = 32'(n) * 32'd4;
    case ({ld, full, asc})
      3'b010: begin st = b - s;        fin = b - s; end
      3'b000: begin st = b - s + 32'd4; fin = b - s; end
      3'b011: begin st = b + 32'd4;     fin = b + s; end
      3'b001: begin st = b;             fin = b + s; end
      3'b110: begin st = b;             fin = b + s; end
      3'b100: begin st = b + 32'd4;     fin = b + s; end
      3'b111: begin st = b - s + 32'd4; fin = b - s; end
      default: begin st = b - s;        fin = b - s; end
    endcase
  endtask

  task automatic run_case(input string req, input logic [31:0] base, input logic [15:0] list,
                          input bit ld, input bit full, input bit asc, input bit wb,
                          input bit rstr, input bit stall, input bit exp_err);
    logic [31:0] st, fin;
    bit ef, ea, ew;
    int n, seen, cyc, last_acc, exp_reg;
    bit got_done;
    logic [15:0] left;
    n = 0;
    for (int i = 0; i < 16; i++) n += int'(list[i]);
    ef = rstr ? 1'b1 : full;
    ea = rstr ? 1'b0 : asc;
    ew = rstr ? 1'b1 : wb;
    plan(base, n, ld, ef, ea, st, fin);
    @(negedge clk);
    chk(req_ready, "R10", "ready when idle", 32'(req_ready), 32'd1);
    req_base = base; req_list = list; req_load = ld; req_full = full;
    req_asc = asc; req_wb = wb; req_rstr = rstr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    req_list = 16'hFFFF; req_base = 32'hDEAD_BEEF;
    seen = 0; cyc = 0; last_acc = -10; got_done = 1'b0; left = list;
    while (!got_done && cyc < 200) begin
      acc_ready = stall ? cyc[0] : 1'b1;
      #1;
      if (acc_valid && acc_ready) begin
        exp_reg = 0;
        for (int i = 15; i >= 0; i--) if (left[i]) exp_reg = i;
        chk(acc_reg == 4'(exp_reg), "R1", {req, " reg order"}, 32'(acc_reg), 32'(exp_reg));
        chk(acc_addr == st + 32'(seen) * 32'd4, "R3", {req, " address"}, acc_addr, st + 32'(seen) * 32'd4);
        chk(acc_addr[1:0] == 2'b00, "R5", {req, " aligned"}, 32'(acc_addr[1:0]), 32'd0);
        chk(acc_load == ld, "R1", {req, " direction"}, 32'(acc_load), 32'(ld));
        left[exp_reg] = 1'b0;
        seen++;
        last_acc = cyc;
      end
      if (done) begin
        got_done = 1'b1;
        if (n == 0 || exp_err)
          chk(cyc == 0, "R10", {req, " done timing"}, 32'(cyc), 32'd0);
        else
          chk(cyc == last_acc + 1, "R10", {req, " done timing"}, 32'(cyc), 32'(last_acc + 1));
      end
      @(negedge clk);
      cyc++;
    end
    acc_ready = 1'b1;
    chk(got_done, "R10", {req, " done seen"}, 32'(got_done), 32'd1);
    if (n == 0) begin
      chk(seen == 0, "R6", {req, " no access"}, 32'(seen), 32'd0);
      chk(illegal == 1'b1, "R6", {req, " illegal"}, 32'(illegal), 32'd1);
      chk(wb_en == 1'b0, "R6", {req, " no writeback"}, 32'(wb_en), 32'd0);
    end else if (exp_err) begin
      chk(seen == 0, "R8", {req, " no access"}, 32'(seen), 32'd0);
      chk(err == 1'b1, "R8", {req, " err"}, 32'(err), 32'd1);
      chk(wb_en == 1'b0, "R8", {req, " no writeback"}, 32'(wb_en), 32'd0);
    end else begin
      chk(seen == n, "R1", {req, " access count"}, 32'(seen), 32'(n));
      chk(err == 1'b0 && illegal == 1'b0, "R7", {req, " flags clear"}, {30'd0, err, illegal}, 32'd0);
      chk(wb_en == ew, "R4", {req, " wb enable"}, 32'(wb_en), 32'(ew));
      chk(wb_value == fin, "R4", {req, " wb value"}, wb_value, fin);
    end
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(req_ready == 1'b1, "R11", "ready in reset", 32'(req_ready), 32'd1);
    chk(acc_valid == 1'b0 && done == 1'b0, "R11", "valid/done in reset", {30'd0, acc_valid, done}, 32'd0);
    chk(wb_en == 1'b0 && illegal == 1'b0 && err == 1'b0, "R11", "flags in reset",
        {29'd0, wb_en, illegal, err}, 32'd0);
    rst_n = 1'b1;
    // R3 stores, four shapes
    run_case("R3 st FD", 32'h0000_1000, 16'h4013, 0, 1, 0, 1, 0, 0, 0);
    run_case("R3 st ED", 32'h0000_1000, 16'h4013, 0, 0, 0, 1, 0, 0, 0);
    run_case("R3 st FA", 32'h0000_1000, 16'h4013, 0, 1, 1, 1, 0, 1, 0);
    run_case("R3 st EA", 32'h0000_1000, 16'h4013, 0, 0, 1, 0, 0, 0, 0);
    // R3 loads, four shapes
    run_case("R3 ld FD", 32'h0000_2000, 16'h8101, 1, 1, 0, 1, 0, 0, 0);
    run_case("R3 ld ED", 32'h0000_2000, 16'h8101, 1, 0, 0, 1, 0, 1, 0);
    run_case("R3 ld FA", 32'h0000_2000, 16'h8101, 1, 1, 1, 0, 0, 0, 0);
    run_case("R3 ld EA", 32'h0000_2000, 16'h8101, 1, 0, 1, 1, 0, 0, 0);
    // R9 full list with stalls; R2 ascending addresses
    run_case("R9 all regs", 32'h0000_4000, 16'hFFFF, 0, 1, 0, 1, 0, 1, 0);
    run_case("R2 single r15", 32'h0000_0100, 16'h8000, 1, 1, 0, 0, 0, 0, 0);
    // R5 unaligned base ignored low bits
    run_case("R5 unaligned", 32'h0000_3003, 16'h00F0, 0, 0, 1, 1, 0, 0, 0);
    // R4 wrap-around below zero
    run_case("R4 wrap", 32'h0000_0004, 16'h000F, 0, 1, 0, 1, 0, 0, 0);
    // R6 empty list
    run_case("R6 empty", 32'h0000_5000, 16'h0000, 0, 1, 0, 1, 0, 0, 0);
    // R7 restricted push with link, shape flags overridden
    run_case("R7 push lr", 32'h0000_6000, 16'h40F1, 0, 0, 1, 0, 1, 0, 0);
    run_case("R7 pop pc", 32'h0000_6000, 16'h8003, 1, 0, 1, 0, 1, 1, 0);
    // R8 restricted violations
    run_case("R8 push pc", 32'h0000_6000, 16'h8001, 0, 1, 0, 1, 1, 0, 1);
    run_case("R8 pop lr", 32'h0000_6000, 16'h4001, 1, 1, 0, 1, 1, 0, 1);
    run_case("R8 high r8", 32'h0000_6000, 16'h0100, 0, 1, 0, 1, 1, 0, 1);
    // recovery after an error
    run_case("R7 after err", 32'h0000_7000, 16'h0080, 1, 1, 0, 1, 1, 0, 0);
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule